// File: doc/BRIEF.md
# Burst Random Word Generator

This block gives a sequencer a fresh random word on every step. A serial random bit stream comes in on one pin and stands in for a digitised noise comparator. The sequencer's step clock comes in on another. Both are sampled by one fast system clock. The step clock passes through a synchroniser and an edge detector.

Each rising step edge opens a shift window that lasts a fixed number of system cycles. Inside the window a divided shift tick pushes the registered noise bit into a staging register, which gives a burst of roughly a dozen shifts per step. Each falling step edge starts a strobe of fixed length. On the last cycle of the strobe, the staging register is copied into an output latch, so the outputs move once per step and never ripple while bits are being shifted.

The whole latched word is an output. Its low bits are also given as a narrow selection slice that picks a sequencer step. A one-cycle flag marks each new word. The window length, the shift divider and the strobe length are parameters counted in system clock cycles.

Top module: `noise_burst_word_gen`

## Requirements
- R1: After a synchronous reset, the word output is 0, the selection slice is 0, the valid flag is low and no shift window is open.
- R2: A rising step edge opens a window of WINDOW_CYC cycles that holds floor(WINDOW_CYC/SHIFT_DIV) shifts, spaced SHIFT_DIV cycles apart. The n-th shift (n counted from 1) stores the noise input as sampled on the clock edge that comes n*SHIFT_DIV+1 edges after the first edge that samples the step clock high.
- R3: Each shift moves the staging word up by one bit position and puts the new noise bit in bit 0. The oldest bit therefore sits highest.
- R4: Noise values that are present only on edges other than the sampling edges of R2 have no effect on the word.
- R5: The word output and the selection slice stay unchanged while a window is shifting, and stay unchanged at every other time except on a latch edge.
- R6: The latch edge comes STROBE_CYC+2 clock edges after the first edge that samples the step clock low. The output then takes the staging value that holds at that edge.
- R7: The valid flag is high for exactly the one cycle that follows a latch edge, and low at all other times.
- R8: The selection slice equals bits [SEL_W-1:0] of the latched word.
- R9: When a window holds fewer than WORD_W shifts, the staging bits from earlier steps move up and are not cleared.
- R10: A reset during an open window closes the window. No latch follows, and the staging register restarts at zero, so the next word holds only new bits above zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_clk_i | input | 1 | Sequencer step clock, asynchronous |
| noise_bit_i | input | 1 | Serial random bit stream |
| word_o | output | WORD_W | Latched random word |
| sel_o | output | SEL_W | Low slice of the latched word, for step selection |
| word_valid_o | output | 1 | One-cycle pulse after each new word is latched |

## Verification
The condition that is hardest to reach from the ports is a window that holds fewer shifts than the word is wide. In that case, bits from earlier steps must still show, moved up. A second instance with a short window runs on the same step and noise inputs as the main one, so every step checks partial fill against the full-fill result. The bench also records the noise input on every edge. It then drives constant, alternating, sparse and pseudo-random patterns, so that a wrong sampling edge or a wrong shift count changes the predicted word. A reset inside an open window, with the step clock dropped at the same time, shows that no stale strobe follows and that the short instance restarts from zeros.

// File: rtl/nbw_pkg.sv
package nbw_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } step_edge_t;

  // Width of a down counter that must hold maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Shifts that fit in one window.
  function automatic int unsigned shifts_per_step(input int unsigned win,
                                                  input int unsigned div);
    return win / div;
  endfunction

endpackage

// File: rtl/nbw_step_sync.sv
module nbw_step_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  output nbw_pkg::step_edge_t edges_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], step_i};
      prev_q <= chain[STAGES-1];
    end
  end

  assign edges_o.rise = chain[STAGES-1] & ~prev_q;
  assign edges_o.fall = ~chain[STAGES-1] & prev_q;

endmodule

// File: rtl/nbw_burst_window.sv
module nbw_burst_window #(
  parameter int unsigned WINDOW_CYC = 5000,
  parameter int unsigned SHIFT_DIV  = 420
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  output logic window_open_o,
  output logic shift_tick_o
);

  localparam int unsigned CW = nbw_pkg::cnt_width(WINDOW_CYC);
  localparam int unsigned DW = nbw_pkg::cnt_width(SHIFT_DIV);

  logic [CW-1:0] win_cnt;
  logic [DW-1:0] div_cnt;

  assign window_open_o = (win_cnt != '0);
  assign shift_tick_o  = window_open_o && (div_cnt == DW'(SHIFT_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      div_cnt <= '0;
    end else if (open_i) begin
      win_cnt <= CW'(WINDOW_CYC);
      div_cnt <= '0;
    end else if (window_open_o) begin
      win_cnt <= win_cnt - CW'(1);
      div_cnt <= shift_tick_o ? '0 : div_cnt + DW'(1);
    end
  end

endmodule

// File: rtl/nbw_stage_shift.sv
module nbw_stage_shift #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              noise_i,
  input  logic              shift_i,
  output logic [WORD_W-1:0] stage_o
);

  logic noise_q;

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      noise_q <= 1'b0;
      stage_o <= '0;
    end else begin
      noise_q <= noise_i;
      if (shift_i) stage_o <= push_bit(stage_o, noise_q);
    end
  end

endmodule

// File: rtl/nbw_strobe_latch.sv
module nbw_strobe_latch #(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned STROBE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] stage_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int unsigned SW = nbw_pkg::cnt_width(STROBE_CYC);

  logic [SW-1:0] s_cnt;

  assign load_o = (s_cnt == SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cnt   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_o;
      if (load_o) word_o <= stage_i;
      if (start_i)             s_cnt <= SW'(STROBE_CYC);
      else if (s_cnt != '0)    s_cnt <= s_cnt - SW'(1);
    end
  end

endmodule

// File: rtl/noise_burst_word_gen.sv
module noise_burst_word_gen #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SEL_W       = 5,
  parameter int unsigned WINDOW_CYC  = 5000,
  parameter int unsigned SHIFT_DIV   = 420,
  parameter int unsigned STROBE_CYC  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_clk_i,
  input  logic              noise_bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              word_valid_o
);

  nbw_pkg::step_edge_t edges;
  logic                step_rise;
  logic                step_fall;
  logic                window_open;
  logic                shift_tick;
  logic                strobe_load;
  logic [WORD_W-1:0]   stage_word;

  nbw_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .step_i(step_clk_i), .edges_o(edges)
  );

  assign step_rise = edges.rise;
  assign step_fall = edges.fall;

  nbw_burst_window #(.WINDOW_CYC(WINDOW_CYC), .SHIFT_DIV(SHIFT_DIV)) u_window (
    .clk(clk), .rst(rst), .open_i(step_rise),
    .window_open_o(window_open), .shift_tick_o(shift_tick)
  );

  nbw_stage_shift #(.WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst(rst), .noise_i(noise_bit_i),
    .shift_i(shift_tick), .stage_o(stage_word)
  );

  nbw_strobe_latch #(.WORD_W(WORD_W), .STROBE_CYC(STROBE_CYC)) u_latch (
    .clk(clk), .rst(rst), .start_i(step_fall), .stage_i(stage_word),
    .load_o(strobe_load), .word_o(word_o), .valid_o(word_valid_o)
  );

  assign sel_o = word_o[SEL_W-1:0];

endmodule

// File: rtl/nbw_checker.sv
module nbw_checker #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step_rise,
  input logic              window_open,
  input logic              shift_tick,
  input logic              strobe_load,
  input logic [WORD_W-1:0] stage_word,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);

  // R1 and R10: reset leaves a cleared word, no flag and no window
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (word_o == '0 && !word_valid_o && !window_open));

  assert_rise_opens_R2: assert property (@(posedge clk) disable iff (rst)
    step_rise |=> window_open);

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (rst)
    shift_tick |=> (stage_word[WORD_W-1:1] == $past(stage_word[WORD_W-2:0])));

  assert_idle_stage_R3: assert property (@(posedge clk) disable iff (rst)
    (!window_open && !step_rise) |=> $stable(stage_word));

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe_load |=> $stable(word_o));

  assert_latch_copy_R6: assert property (@(posedge clk) disable iff (rst)
    strobe_load |=> (word_o == $past(stage_word)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    strobe_load |=> word_valid_o);

  assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe_load |=> !word_valid_o);

endmodule

bind noise_burst_word_gen nbw_checker #(.WORD_W(WORD_W)) u_nbw_chk (
  .clk(clk), .rst(rst), .step_rise(step_rise), .window_open(window_open),
  .shift_tick(shift_tick), .strobe_load(strobe_load), .stage_word(stage_word),
  .word_o(word_o), .word_valid_o(word_valid_o)
);

// File: tb/noise_burst_word_gen_test.sv
module noise_burst_word_gen_test;

  localparam int WIN_L = 20;
  localparam int WIN_S = 6;
  localparam int DIV   = 2;
  localparam int STB   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step = 1'b0;
  logic       noise = 1'b0;
  logic [7:0] word_l, word_s;
  logic [4:0] sel_l, sel_s;
  logic       vld_l, vld_s;

  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  int          mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hist [0:16383];
  logic [7:0]  exp_l = 8'h00;
  logic [7:0]  exp_s = 8'h00;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  noise_burst_word_gen #(.WORD_W(8), .SEL_W(5), .WINDOW_CYC(WIN_L),
    .SHIFT_DIV(DIV), .STROBE_CYC(STB), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .step_clk_i(step), .noise_bit_i(noise),
    .word_o(word_l), .sel_o(sel_l), .word_valid_o(vld_l));

  noise_burst_word_gen #(.WORD_W(8), .SEL_W(5), .WINDOW_CYC(WIN_S),
    .SHIFT_DIV(DIV), .STROBE_CYC(STB), .SYNC_STAGES(2)) uut_short (
    .clk(clk), .rst(rst), .step_clk_i(step), .noise_bit_i(noise),
    .word_o(word_s), .sel_o(sel_s), .word_valid_o(vld_s));

  // Noise driver: the value set now is sampled on edge cyc+1.
  always @(negedge clk) begin
    logic nb;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      1:       nb = 1'b1;
      2:       nb = 1'b0;
      3:       nb = cyc[0];
      4:       nb = (cyc % 3 == 0);
      default: nb = lfsr[0];
    endcase
    noise = nb;
    if (cyc < 16383) hist[cyc + 1] = nb;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // n-th shift takes the noise seen on edge k+2+n*DIV (k = edges before step rose)
  function automatic logic [7:0] predict(input int k, input int win, input logic [7:0] prev);
    logic [7:0] w = prev;
    for (int j = 0; j < win; j++)
      if (j % DIV == DIV - 1) w = {w[6:0], hist[k + 3 + j]};
    return w;
  endfunction

  task automatic run_step(input int m);
    int k, f;
    logic [7:0] el, es;
    @(negedge clk);
    mode = m;
    @(negedge clk);
    step = 1'b1;
    k = cyc;
    repeat (8) @(negedge clk);
    chk("R5 word held while shifting (long)", word_l, exp_l);
    chk("R5 word held while shifting (short)", word_s, exp_s);
    repeat (WIN_L) @(negedge clk);
    el = predict(k, WIN_L, exp_l);
    es = predict(k, WIN_S, exp_s);
    step = 1'b0;
    f = cyc;
    repeat (STB + 2) @(negedge clk);
    chk("R6 no latch before strobe end", word_l, exp_l);
    chk("R7 valid low before latch", vld_l, 1'b0);
    @(negedge clk);
    chk("R2 R3 R4 latched word (long)", word_l, el);
    chk("R9 partial-fill word (short)", word_s, es);
    chk("R7 valid pulse (long)", vld_l, 1'b1);
    chk("R7 valid pulse (short)", vld_s, 1'b1);
    chk("R8 selection slice (long)", sel_l, el[4:0]);
    chk("R8 selection slice (short)", sel_s, es[4:0]);
    @(negedge clk);
    chk("R7 valid one cycle only", vld_l, 1'b0);
    exp_l = el;
    exp_s = es;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", word_l, 8'h00);
    chk("R1 reset slice", sel_l, 5'h00);
    chk("R1 reset valid", vld_l, 1'b0);
    repeat (5) @(negedge clk);
    chk("R1 idle word stays zero", word_s, 8'h00);

    for (int m = 0; m < 5; m++)
      for (int r = 0; r < 4; r++) run_step(m);
    for (int r = 0; r < 10; r++) run_step(0);

    // R10: reset inside an open window
    @(negedge clk);
    mode = 0;
    step = 1'b1;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    step = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 word cleared", word_l, 8'h00);
    chk("R10 valid low", vld_l, 1'b0);
    repeat (STB + 6) @(negedge clk);
    chk("R10 no stale latch", word_s, 8'h00);
    chk("R10 no stale valid", vld_s, 1'b0);
    exp_l = 8'h00;
    exp_s = 8'h00;
    run_step(1);
    run_step(0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule